// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Unit

This unit holds the event-status, event-clear and interrupt-enable registers of an SD card host controller. The command path, data path and FIFO logic each raise one-cycle event pulses. The unit latches every pulse into a sticky status bit, and the bit stays set until software clears it. A separate clear register does the clearing: writing a 1 to a bit position of that register clears the matching status bit. A per-bit enable register chooses which of the sticky events drive the single, level-sensitive interrupt line.

The card-detect and write-protect pins are asynchronous. Each passes through a two-flop synchronizer before it is used. Their synchronized levels appear as two live status bits, and these two bits are never latched. The unit also watches the synchronized card-detect level and latches a card-change event on either edge of it. It ignores the level that is present when reset is released.

Software reaches the unit through a simple register port with a byte offset, a write strobe and a read strobe. Read data is registered.

Top module: `sdh_status_unit`

## Requirements
- R1: After synchronous reset the sticky status bits, the enable register, the read data register and `irq_o` are all 0.
- R2: The status word at offset 40 holds its sticky bits in this order, from bit 0 upward: response CRC error, data CRC error, response timeout, data timeout, response CRC good, data CRC good, command issued, data done, FIFO underrun, FIFO overrun, card change. A 1 on `evt_i[k]` (k = 0..9) in a cycle sets bit k at the next clock edge. The bit then stays set after the pulse has ended.
- R3: A write to offset 44 clears each sticky bit k (0..10) for which write data bit k is 1. Bits whose write data is 0 keep their value.
- R4: When an event on bit k and a clear of bit k fall in the same cycle, bit k is 1 afterwards.
- R5: Writes to offset 40 change no status bit.
- R6: The enable register at offset 48 stores write data bits 0..10, which share their positions with the status bits. It reads back those bits, and bits 11 and up of the register read as 0.
- R7: `irq_o` is registered. It is high one cycle after any status bit 0..10 is 1 while its enable bit is also 1. It stays high until all such bits are cleared or disabled, and it falls one cycle after that happens.
- R8: Status bit 11 is the synchronized card-detect level, where 1 means no card is present. Status bit 12 is the synchronized write-protect level. Neither bit is affected by the clear register.
- R9: Card change (status bit 10) is set on either edge of the synchronized card-detect level. It is not set by the level that is present when reset is released.
- R10: A read strobe captures the addressed register into `reg_rdata` at the next clock edge. When no read strobe is present, `reg_rdata` holds its value. Offsets other than 40 and 48 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| evt_i | input | 10 | Event pulses for status bits 0..9 |
| cd_pin | input | 1 | Asynchronous card-detect level (1 = no card) |
| wp_pin | input | 1 | Asynchronous write-protect level |
| irq_o | output | 1 | Level interrupt |

## Verification
A sticky bit that is lost or stuck shows up at `reg_rdata` on the first status read that follows the event or clear. If the bit is enabled, it also shows on `irq_o` one cycle after the status edge. A mis-timed interrupt register moves `irq_o` by one cycle, and the bench samples `irq_o` in the exact cycle where it must change. Card-change errors show up as spurious or missing bit-10 events, both after a reset taken with no card present and after pin edges in each direction.

// File: rtl/sdh_stat_pkg.sv
package sdh_stat_pkg;
  localparam int EXT_EVTS  = 10;
  localparam int STICKY_N  = 11;
  localparam int CHG_BIT   = 10;
  localparam int CD_BIT    = 11;
  localparam int WP_BIT    = 12;
  localparam int LIVE_TOP  = 13;
  localparam int OFS_STAT  = 40;
  localparam int OFS_CLR   = 44;
  localparam int OFS_EN    = 48;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/sdh_sync_bank.sv
module sdh_sync_bank #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stg[s] <= stg[s-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdh_cd_watch.sv
module sdh_cd_watch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cd_s,
  output logic chg
);
  localparam int ARM_LIM = STAGES + 1;
  localparam int CW      = $clog2(ARM_LIM + 1);

  logic          cd_q;
  logic [CW-1:0] arm_cnt;
  logic          armed;

  assign armed = (arm_cnt == CW'(ARM_LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_q    <= 1'b0;
      arm_cnt <= '0;
    end else begin
      cd_q <= cd_s;
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
    end
  end

  assign chg = armed & (cd_s ^ cd_q);

  // R9
  chg_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    chg |-> (cd_s != $past(cd_s)));
endmodule

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat;
  logic [N-1:0] nxt;

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    assign nxt[gi] = set_i[gi] | (stat[gi] & ~clr_i[gi]);
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= nxt;
  end

  assign stat_o = stat;

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((stat & $past(set_i)) == $past(set_i)));
  // R3
  clear_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((stat & $past(clr_i & ~set_i)) == '0));
  // R3
  untouched_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(set_i | clr_i)) == ($past(stat) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/sdh_status_unit.sv
module sdh_status_unit
  import sdh_stat_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [EXT_EVTS-1:0] evt_i,
  input  logic                cd_pin,
  input  logic                wp_pin,
  output logic                irq_o
);
  localparam int PAD_W = DATA_W - LIVE_TOP;

  logic [1:0]          pins_s;
  logic                cd_s, wp_s, cd_chg;
  logic [STICKY_N-1:0] set_v, clr_v, stat, en_q;
  logic                hit_stat, hit_clr, hit_en;
  rd_sel_e             rd_sel;
  logic [DATA_W-1:0]   rd_val;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:STICKY_N];

  sdh_sync_bank #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({wp_pin, cd_pin}), .q(pins_s)
  );
  assign cd_s = pins_s[0];
  assign wp_s = pins_s[1];

  sdh_cd_watch #(.STAGES(SYNC_STAGES)) u_cdw (
    .clk(clk), .rst(rst), .cd_s(cd_s), .chg(cd_chg)
  );

  assign hit_stat = (int'(reg_addr) == OFS_STAT);
  assign hit_clr  = (int'(reg_addr) == OFS_CLR);
  assign hit_en   = (int'(reg_addr) == OFS_EN);

  assign set_v = {cd_chg, evt_i};
  assign clr_v = (reg_wr && hit_clr) ? reg_wdata[STICKY_N-1:0] : '0;

  sdh_sticky_bank #(.N(STICKY_N)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .stat_o(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (reg_wr && hit_en) en_q <= reg_wdata[STICKY_N-1:0];
  end

  always_comb begin
    if (hit_stat)    rd_sel = SEL_STAT;
    else if (hit_en) rd_sel = SEL_EN;
    else             rd_sel = SEL_NONE;
  end

  always_comb begin
    case (rd_sel)
      SEL_STAT: rd_val = {{PAD_W{1'b0}}, wp_s, cd_s, stat};
      SEL_EN:   rd_val = {{(DATA_W-STICKY_N){1'b0}}, en_q};
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_val;
      irq_o <= |(stat & en_q);
    end
  end

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & en_q)) |=> irq_o);
  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & en_q)) |=> !irq_o);
  // R5
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && hit_stat && !(|set_v)) |=> (stat == $past(stat)));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_sdh_status_unit.sv
module tb_sdh_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  evt_i = '0;
  logic        cd_pin = 1'b1, wp_pin = 1'b0;
  logic        irq_o;

  int n_cmp = 0, n_bad = 0;
  logic rd_seen = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  sdh_status_unit dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_i(evt_i), .cd_pin(cd_pin), .wp_pin(wp_pin), .irq_o(irq_o)
  );

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic rd_reg(input int ofs, input logic [31:0] exp, input string tag);
    sb_q.push_back('{exp, tag});
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'(ofs);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input int ofs, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 8'(ofs); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] m);
    @(negedge clk); evt_i = m;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_cmp++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq_o, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    n_cmp++;
    if (reg_rdata !== 32'h0) begin
      n_bad++; $display("FAIL R1: rdata=%h expected=0", reg_rdata);
    end
    repeat (4) @(negedge clk);
    // R8 live no-card level, R9 no change latched from reset level
    rd_reg(40, 32'h800, "R9 R8 status after reset with no card");
    rd_reg(48, 32'h0, "R1 enable after reset");
    // R2 sticky events
    pulse(10'h001);
    rd_reg(40, 32'h801, "R2 bit0 sticky");
    pulse(10'h280);
    rd_reg(40, 32'hA81, "R2 bits7,9 sticky");
    // R5 status writes ignored
    wr_reg(40, 32'hFFFF_FFFF);
    rd_reg(40, 32'hA81, "R5 write to status ignored");
    // R3 clear
    wr_reg(44, 32'h1);
    rd_reg(40, 32'hA80, "R3 clear bit0");
    wr_reg(44, 32'h0);
    rd_reg(40, 32'hA80, "R3 zero clear no effect");
    wr_reg(44, 32'h7FF);
    rd_reg(40, 32'h800, "R3 clear all, R8 live bit kept");
    // R4 set wins over clear
    @(negedge clk); evt_i = 10'h008; reg_wr = 1'b1; reg_addr = 8'd44; reg_wdata = 32'h8;
    @(negedge clk); evt_i = '0; reg_wr = 1'b0;
    rd_reg(40, 32'h808, "R4 set beats clear");
    wr_reg(44, 32'h8);
    // R6 enable register
    wr_reg(48, 32'hFFFF_FFFF);
    rd_reg(48, 32'h7FF, "R6 enable width");
    wr_reg(48, 32'h4);
    rd_reg(48, 32'h4, "R6 enable readback");
    // R7 interrupt timing
    @(negedge clk);
    chk_irq(1'b0, "R7 idle");
    @(negedge clk); evt_i = 10'h004;
    @(negedge clk); evt_i = '0;
    chk_irq(1'b0, "R7 one cycle after status");
    @(negedge clk);
    chk_irq(1'b1, "R7 raised");
    pulse(10'h020);
    repeat (3) @(negedge clk);
    chk_irq(1'b1, "R7 level held");
    wr_reg(48, 32'h0);
    @(negedge clk);
    chk_irq(1'b0, "R7 masked off");
    wr_reg(48, 32'h20);
    @(negedge clk);
    chk_irq(1'b1, "R7 other enabled bit");
    wr_reg(44, 32'h24);
    @(negedge clk);
    chk_irq(1'b0, "R7 cleared");
    rd_reg(40, 32'h800, "R3 after irq clear");
    // R9 card insertion edge, R8 live level
    @(negedge clk); cd_pin = 1'b0;
    repeat (5) @(negedge clk);
    rd_reg(40, 32'h400, "R9 falling edge change, R8 card present");
    wr_reg(44, 32'h400);
    rd_reg(40, 32'h0, "R3 change cleared");
    @(negedge clk); cd_pin = 1'b1; wp_pin = 1'b1;
    repeat (5) @(negedge clk);
    rd_reg(40, 32'h1C00, "R9 rising edge change, R8 wp level");
    wr_reg(44, 32'hFFFF);
    rd_reg(40, 32'h1800, "R8 live bits unaffected by clear");
    wr_reg(48, 32'h400);
    @(negedge clk); cd_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk_irq(1'b1, "R9 R7 card change interrupt");
    // R10 unmapped offsets and hold
    rd_reg(0, 32'h0, "R10 unmapped offset 0");
    rd_reg(52, 32'h0, "R10 unmapped offset 52");
    rd_reg(44, 32'h0, "R10 clear offset reads 0");
    repeat (3) @(negedge clk);
    n_cmp++;
    if (reg_rdata !== 32'h0) begin
      n_bad++; $display("FAIL R10: held rdata=%h expected=0", reg_rdata);
    end
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule